// File: doc/BRIEF.md
# Split Condition Register File

This block holds a 32-bit condition register as eight independent 4-bit fields, CR0 to CR7. Each field is its own register, so each can be read and written by a port that cares only about that field. The block has three narrow read ports and two narrow write ports that each carry one field. It also has one wide read port and one wide write port that span the whole 32-bit register.

Every port picks its fields with a field mask that has one bit per field, not with an encoded address. A narrow port sets at most one mask bit. The wide ports may set any number of bits, so a single wide write can update any subset of fields in one cycle without reading them first. Reads are combinational and pass through any write landing on the same field in the same cycle. Stored values change at the next rising clock edge.

A core uses the narrow ports for instructions that touch one field and the wide ports for instructions that move the whole register. Both kinds of access can be in flight in the same cycle. The block does not decode instructions and gives no meaning to the bits of a field.

Top module: `cond_field_regfile`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all eight fields clear to zero. After reset, a wide read with all mask bits set returns 0x00000000.
- R2: A narrow write port p whose mask has bit k set stores `nw_data[4p+3:4p]` into field k at the next rising edge. No other field changes.
- R3: Narrow read port p returns field k on `nr_data[4p+3:4p]` when bit 8p+k of `nr_en` is set. It returns zero when its eight mask bits are all zero. The narrow masks are one-hot or zero.
- R4: On the wide read port, field k appears on bits [31-4k:28-4k] when `fr_en[k]` is set, so CR0 is the most significant nibble. Fields whose mask bit is clear read as zero.
- R5: A wide write updates, at the next rising edge, exactly those fields k whose `fw_en[k]` is set. Each takes bits [31-4k:28-4k] of `fw_data`. Any number of mask bits may be set at once.
- R6: A read of a field that a port writes in the same cycle returns the value being written, in that same cycle.
- R7: When several write ports select the same field in one cycle, narrow port 0 wins over narrow port 1, and narrow port 1 wins over the wide port. The winner's value is both stored and passed through to readers.
- R8: A field selected by no write port keeps its value across the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nr_en | input | 24 | Field masks of the three narrow read ports, port p in bits [8p+7:8p] |
| nr_data | output | 12 | Narrow read data, port p in bits [4p+3:4p] |
| nw_en | input | 16 | Field masks of the two narrow write ports, port p in bits [8p+7:8p] |
| nw_data | input | 8 | Narrow write data, port p in bits [4p+3:4p] |
| fr_en | input | 8 | Wide read field mask |
| fr_data | output | 32 | Wide read data, field k in bits [31-4k:28-4k] |
| fw_en | input | 8 | Wide write field mask |
| fw_data | input | 32 | Wide write data, field k in bits [31-4k:28-4k] |

## Verification
Two things can land on the same field in one cycle: a write from more than one write port, and a read through the bypass path of a field that is being written. The random stimulus drives all five ports together with dense masks, so these collisions occur often. Directed cycles force all three writers onto one field while a narrow reader and the wide reader watch it. Each read is compared, in the same cycle, against a reference that resolves the writers in priority order. The stored result is then read back in the following cycle.

// File: rtl/cfr_pkg.sv
// Package: shared geometry of the split condition register.
// Assumes fields are numbered from the most significant nibble downward.
package cfr_pkg;
    localparam int FIELD_W    = 4;
    localparam int NUM_FIELDS = 8;
    localparam int REG_W      = FIELD_W * NUM_FIELDS;
    localparam int NARROW_RD  = 3;
    localparam int NARROW_WR  = 2;

    // Lowest bit of field k inside the wide register word
    function automatic int field_lsb(input int k);
        return REG_W - FIELD_W * (k + 1);
    endfunction
endpackage

// File: rtl/cfr_field_cell.sv
// Module: one field of the condition register.
// Resolves the write ports that select this field, with lower narrow
// index first and the wide port last, stores the winner, and exposes
// the value that readers see this cycle (write-through).
// Assumes the caller has already sliced the masks down to this field.
module cfr_field_cell #(
    parameter int FW  = 4,
    parameter int NWR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NWR-1:0]    nw_sel,
    input  logic [NWR*FW-1:0] nw_val,
    input  logic              fw_sel,
    input  logic [FW-1:0]     fw_val,
    output logic [FW-1:0]     q,
    output logic [FW-1:0]     thru
);
    // Pick the winning writer, falling back to the stored value
    always_comb begin
        thru = q;
        if (fw_sel) thru = fw_val;
        for (int p = NWR - 1; p >= 0; p--) begin
            if (nw_sel[p]) thru = nw_val[p*FW +: FW];
        end
    end

    // Store the resolved value; synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= thru;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> q == '0);

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nw_sel == '0 && !fw_sel) |=> $stable(q));

    p_port0_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nw_sel[0] |=> q == $past(nw_val[FW-1:0]));

    p_wide_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_sel && nw_sel == '0) |=> q == $past(fw_val));
endmodule

// File: rtl/cfr_narrow_rd.sv
// Module: one narrow read port.
// Returns the field picked by a one-hot mask, or zero for an empty mask.
// Assumes the mask is one-hot or zero.
module cfr_narrow_rd #(
    parameter int NF = 8,
    parameter int FW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NF-1:0]    sel,
    input  logic [NF*FW-1:0] fields,
    output logic [FW-1:0]    data
);
    // OR together the selected field
    always_comb begin
        data = '0;
        for (int k = 0; k < NF; k++) begin
            if (sel[k]) data = data | fields[k*FW +: FW];
        end
    end

    p_mask_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/cfr_wide_rd.sv
// Module: wide read port.
// Places each selected field in its nibble, field 0 at the top; clears
// the nibbles of fields that are not selected.
module cfr_wide_rd #(
    parameter int NF = 8,
    parameter int FW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NF-1:0]    sel,
    input  logic [NF*FW-1:0] fields,
    output logic [NF*FW-1:0] data
);
    localparam int RW = NF * FW;

    // Gate each field into its nibble
    always_comb begin
        data = '0;
        for (int k = 0; k < NF; k++) begin
            if (sel[k]) data[RW - FW*(k+1) +: FW] = fields[k*FW +: FW];
        end
    end

    p_empty_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> (data == '0));
endmodule

// File: rtl/cond_field_regfile.sv
// Module: split condition register file, top level.
// Eight field cells, narrow ports that reach one field each, and wide
// ports that reach any subset. All reads see same-cycle writes.
// Assumes narrow masks are one-hot or zero; the wide masks are free.
module cond_field_regfile
    import cfr_pkg::*;
#(
    parameter int FW  = cfr_pkg::FIELD_W,
    parameter int NF  = cfr_pkg::NUM_FIELDS,
    parameter int NRD = cfr_pkg::NARROW_RD,
    parameter int NWR = cfr_pkg::NARROW_WR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NRD*NF-1:0] nr_en,
    output logic [NRD*FW-1:0] nr_data,
    input  logic [NWR*NF-1:0] nw_en,
    input  logic [NWR*FW-1:0] nw_data,
    input  logic [NF-1:0]     fr_en,
    output logic [NF*FW-1:0]  fr_data,
    input  logic [NF-1:0]     fw_en,
    input  logic [NF*FW-1:0]  fw_data
);
    localparam int RW = NF * FW;

    logic [NF*FW-1:0] stored;
    logic [NF*FW-1:0] visible;

    for (genvar k = 0; k < NF; k++) begin : g_field
        logic [NWR-1:0] sel_k;

        // Gather the narrow write masks for field k
        always_comb begin
            for (int p = 0; p < NWR; p++) sel_k[p] = nw_en[p*NF + k];
        end

        cfr_field_cell #(.FW(FW), .NWR(NWR)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .nw_sel (sel_k),
            .nw_val (nw_data),
            .fw_sel (fw_en[k]),
            .fw_val (fw_data[RW - FW*(k+1) +: FW]),
            .q      (stored[k*FW +: FW]),
            .thru   (visible[k*FW +: FW])
        );

        p_wide_vs_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (fr_en[k] && nr_en[k]) |-> fr_data[RW - FW*(k+1) +: FW] == nr_data[FW-1:0]);
    end

    for (genvar p = 0; p < NRD; p++) begin : g_nrd
        cfr_narrow_rd #(.NF(NF), .FW(FW)) u_rd (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (nr_en[p*NF +: NF]),
            .fields (visible),
            .data   (nr_data[p*FW +: FW])
        );
    end

    cfr_wide_rd #(.NF(NF), .FW(FW)) u_wrd (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (fr_en),
        .fields (visible),
        .data   (fr_data)
    );

    for (genvar p = 0; p < NWR; p++) begin : g_nwr_chk
        p_nw_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(nw_en[p*NF +: NF]));
    end
endmodule

// File: tb/cond_field_regfile_tb.sv
module cond_field_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] nr_en = '0;
    logic [11:0] nr_data;
    logic [15:0] nw_en = '0;
    logic [7:0]  nw_data = '0;
    logic [7:0]  fr_en = '0;
    logic [31:0] fr_data;
    logic [7:0]  fw_en = '0;
    logic [31:0] fw_data = '0;

    logic [3:0] mdl [8];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cond_field_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .nr_en(nr_en), .nr_data(nr_data),
        .nw_en(nw_en), .nw_data(nw_data),
        .fr_en(fr_en), .fr_data(fr_data),
        .fw_en(fw_en), .fw_data(fw_data)
    );

    // Value field k takes this cycle: narrow 0, narrow 1, wide, stored
    function automatic logic [3:0] eff(input int k);
        if (nw_en[k])     return nw_data[3:0];
        if (nw_en[8 + k]) return nw_data[7:4];
        if (fw_en[k])     return fw_data[31 - 4*k -: 4];
        return mdl[k];
    endfunction

    function automatic logic [3:0] exp_narrow(input int p);
        logic [3:0] v = '0;
        for (int k = 0; k < 8; k++) if (nr_en[p*8 + k]) v |= eff(k);
        return v;
    endfunction

    function automatic logic [31:0] exp_wide();
        logic [31:0] v = '0;
        for (int k = 0; k < 8; k++) if (fr_en[k]) v[31 - 4*k -: 4] = eff(k);
        return v;
    endfunction

    function automatic logic [7:0] rnd_onehot0();
        int r = $urandom % 10;
        return (r < 8) ? 8'(1 << r) : 8'h00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Inputs are already driven (after a negedge): check reads, clock, update model
    task automatic step(input string tag);
        logic [3:0] nxt [8];
        #1;
        for (int p = 0; p < 3; p++)
            check({tag, " narrow R3 R6 R7"}, 32'(nr_data[p*4 +: 4]), 32'(exp_narrow(p)));
        check({tag, " wide R4 R6 R7"}, fr_data, exp_wide());
        for (int k = 0; k < 8; k++) nxt[k] = eff(k);
        @(posedge clk);
        for (int k = 0; k < 8; k++) mdl[k] = nxt[k];
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        nr_en = '0; nw_en = '0; fw_en = '0; fr_en = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1357_2468));
        for (int k = 0; k < 8; k++) mdl[k] = '0;
        // Reset with writes pending: reset must dominate (R1)
        nw_en = 16'h0101; nw_data = 8'h5A; fw_en = 8'hFF; fw_data = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle_inputs();
        fr_en = 8'hFF;
        #1 check("R1 reset clears all fields", fr_data, 32'h0);
        step("R1");

        // R5: wide write, partial mask only fields 1,4,7
        fw_en = 8'b1001_0010; fw_data = 32'h1234_5678;
        step("R5 partial wide");
        idle_inputs(); fr_en = 8'hFF;
        #1 check("R5 partial wide write readback", fr_data, 32'h0200_5008);
        step("R5 readback");

        // R2: narrow write field 6 from port 1 only
        nw_en = 16'h4000; nw_data = 8'h90;
        step("R2 narrow");
        idle_inputs(); fr_en = 8'hFF;
        #1 check("R2 narrow write field 6", fr_data, 32'h0200_5098);
        step("R2 readback");

        // R3: zero mask narrow read returns zero
        idle_inputs(); nr_en = 24'h0;
        #1 check("R3 empty narrow mask", 32'(nr_data), 32'h0);
        // R8: idle cycle keeps contents
        step("R8 idle");
        fr_en = 8'hFF;
        #1 check("R8 idle hold", fr_data, 32'h0200_5098);
        step("R8 readback");

        // R7 + R6: all three writers hit field 3, readers watch it
        idle_inputs();
        nw_en = 16'h0808; nw_data = 8'h5A; fw_en = 8'hFF; fw_data = 32'hCCCC_CCCC;
        nr_en = 24'h08_0000; fr_en = 8'b0000_1000;
        #1 check("R7 R6 collision narrow read", 32'(nr_data[11:8]), 32'hA);
        check("R7 R6 collision wide read", fr_data, 32'h000A_0000);
        step("R7 collision");
        idle_inputs(); fr_en = 8'hFF;
        #1 check("R7 collision stored", fr_data, 32'hCCCA_CCCC);
        step("R7 readback");

        // R7: narrow 1 beats wide on field 0
        nw_en = 16'h0100; nw_data = 8'h30; fw_en = 8'h01; fw_data = 32'hF000_0000;
        nr_en = 24'h000001;
        #1 check("R7 narrow1 over wide", 32'(nr_data[3:0]), 32'h3);
        step("R7 n1");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            nr_en   = {rnd_onehot0(), rnd_onehot0(), rnd_onehot0()};
            nw_en   = {rnd_onehot0(), rnd_onehot0()};
            nw_data = 8'($urandom);
            fr_en   = 8'($urandom);
            fw_en   = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
            fw_data = $urandom;
            step("random");
        end

        idle_inputs(); fr_en = 8'hFF;
        #1 check("R8 final contents",
                 fr_data, {mdl[0], mdl[1], mdl[2], mdl[3], mdl[4], mdl[5], mdl[6], mdl[7]});
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule